// File: doc/BRIEF.md
# Fractional Pacing Rate Generator

This block holds four independent pacing timers. Each timer issues single-cycle transfer-request pulses to a DMA engine at an average rate of X/Y requests per system clock cycle. X and Y are 16-bit fields packed into one 32-bit read/write configuration word per timer. Every cycle, a phase accumulator inside each timer adds X. When the sum reaches Y, the timer subtracts Y and issues a pulse.

Software writes a configuration word through a simple write strobe with a timer index, and reads any word back through a separate read index. Writing a word restarts that timer from zero phase, so its pulse pattern after a write is deterministic. A timer whose X or Y is zero is stopped. A ratio of one or more saturates at one request per cycle.

Top module: `pace_timer_bank`

## Requirements
- R1: Each configuration word holds X in bits 31:16 and Y in bits 15:0. Both reset to 0, and `rd_data` returns the word selected by `rd_addr` combinationally.
- R2: A write to one timer changes neither the configuration nor the pulse sequence of any other timer.
- R3: A timer whose X is 0 or whose Y is 0 keeps `req` low. This includes the reset state.
- R4: For 0 < X < Y, the k-th clock edge after a write drives `req` for that edge's cycle high exactly when floor(k·X/Y) > floor((k−1)·X/Y). The accumulator always stays below Y.
- R5: For X ≥ Y with both nonzero, `req` is high in every cycle after the first edge following the write.
- R6: A write clears that timer's accumulator. The edge that performs the write leaves `req` low, and phase counting restarts from k = 0 at that edge.
- R7: With a constant configuration 0 < X < Y, any Y consecutive cycles contain exactly X pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Timer index for the write |
| wr_data | input | 32 | Configuration word to write, X in bits 31:16, Y in bits 15:0 |
| rd_addr | input | 2 | Timer index for readback |
| rd_data | output | 32 | Configuration word of the selected timer |
| req | output | 4 | One request pulse bit per timer, registered |

## Verification
The hardest case to reach is a write that lands while other timers are mid-phase, together with a rewrite of a timer that changes its ratio between saturated, stopped and fractional. Random writes are sparse and have small X and Y values, so that full periods, zero fields and X ≥ Y all occur often while the untouched timers keep running. Directed cases cover full 16-bit extremes and a window count over exactly Y cycles.

// File: rtl/pace_pkg.sv
package pace_pkg;
  parameter int FIELD_W = 16;
  localparam int ACC_W  = FIELD_W + 1;
  localparam int WORD_W = 2 * FIELD_W;

  typedef struct packed {
    logic             fire;
    logic [ACC_W-1:0] acc;
  } pace_step_t;

  // One add-compare-subtract step of the phase accumulator.
  function automatic pace_step_t pace_step(input logic [ACC_W-1:0]   acc,
                                           input logic [FIELD_W-1:0] x,
                                           input logic [FIELD_W-1:0] y);
    pace_step_t       r;
    logic [ACC_W-1:0] sum;
    sum = acc + {1'b0, x};
    if (sum >= {1'b0, y}) begin
      r.fire = 1'b1;
      r.acc  = sum - {1'b0, y};
    end else begin
      r.fire = 1'b0;
      r.acc  = sum;
    end
    return r;
  endfunction
endpackage

// File: rtl/pace_cfg_regs.sv
module pace_cfg_regs
  import pace_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  localparam int ADDR_W = $clog2(NUM_TIMERS)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [WORD_W-1:0]                    wr_data,
  input  logic [ADDR_W-1:0]                    rd_addr,
  output logic [WORD_W-1:0]                    rd_data,
  output logic [NUM_TIMERS-1:0][FIELD_W-1:0]   cfg_x,
  output logic [NUM_TIMERS-1:0][FIELD_W-1:0]   cfg_y,
  output logic [NUM_TIMERS-1:0]                restart
);
  logic [NUM_TIMERS-1:0][WORD_W-1:0] word_q;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_word
    assign restart[i] = wr_en && (wr_addr == ADDR_W'(i));
    assign cfg_x[i]   = word_q[i][WORD_W-1:FIELD_W];
    assign cfg_y[i]   = word_q[i][FIELD_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n)          word_q[i] <= '0;
      else if (restart[i]) word_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_TIMERS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = word_q[i];
  end

  AST_ONE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(restart)); // R2
endmodule

// File: rtl/pace_lane.sv
module pace_lane
  import pace_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [FIELD_W-1:0] x,
  input  logic [FIELD_W-1:0] y,
  output logic               req_o
);
  logic [ACC_W-1:0] acc_q;
  pace_step_t       nxt;
  logic             stopped;
  logic             saturated;

  assign stopped   = (x == '0) || (y == '0);
  assign saturated = !stopped && (x >= y);
  assign nxt       = pace_step(acc_q, x, y);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || stopped) begin
      acc_q <= '0;
      req_o <= 1'b0;
    end else if (saturated) begin
      acc_q <= '0;
      req_o <= 1'b1;
    end else begin
      acc_q <= nxt.acc;
      req_o <= nxt.fire;
    end
  end

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> !req_o); // R3
  AST_SAT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (saturated && !restart) |=> req_o); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (acc_q == '0) && !req_o); // R6
  AST_ACC_BELOW_Y: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped |-> (acc_q < {1'b0, y})); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !saturated) |-> (nxt.acc < {1'b0, y})); // R4
endmodule

// File: rtl/pace_timer_bank.sv
module pace_timer_bank
  import pace_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  localparam int ADDR_W = $clog2(NUM_TIMERS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [WORD_W-1:0]     rd_data,
  output logic [NUM_TIMERS-1:0] req
);
  logic [NUM_TIMERS-1:0][FIELD_W-1:0] cfg_x;
  logic [NUM_TIMERS-1:0][FIELD_W-1:0] cfg_y;
  logic [NUM_TIMERS-1:0]              restart;

  pace_cfg_regs #(.NUM_TIMERS(NUM_TIMERS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cfg_x   (cfg_x),
    .cfg_y   (cfg_y),
    .restart (restart)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_lane
    pace_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart[i]),
      .x       (cfg_x[i]),
      .y       (cfg_y[i]),
      .req_o   (req[i])
    );
  end
endmodule

// File: tb/tb_pace_timer_bank.sv
module tb_pace_timer_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  req;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  longint mx [NT];
  longint my [NT];
  longint mk [NT];
  int     win_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  pace_timer_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .req(req)
  );

  // Expected pulse at step k after restart, from floor arithmetic.
  function automatic bit exp_pulse(longint k, longint x, longint y);
    if (k == 0 || x == 0 || y == 0) return 1'b0;
    if (x >= y) return 1'b1;
    return ((k * x) / y) != (((k - 1) * x) / y);
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Called at a negedge: drive, advance one edge, update model, check at next negedge.
  task automatic step(bit we, int wa, logic [31:0] wd, int ra);
    bit other;
    wr_en = we; wr_addr = 2'(wa); wr_data = wd; rd_addr = 2'(ra);
    @(posedge clk);
    for (int i = 0; i < NT; i++) begin
      if (!rst_n) begin
        mx[i] = 0; my[i] = 0; mk[i] = 0;
      end else if (we && wa == i) begin
        mx[i] = wd[31:16]; my[i] = wd[15:0]; mk[i] = 0;
      end else mk[i]++;
    end
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < NT; i++) begin
      bit e;
      string tag;
      e = exp_pulse(mk[i], mx[i], my[i]);
      other = we && (wa != i) && rst_n;
      if (mx[i] == 0 || my[i] == 0) tag = "R3";
      else if (mk[i] == 0) tag = "R6";
      else if (other) tag = "R2";
      else if (mx[i] >= my[i]) tag = "R5";
      else tag = "R4";
      check(req[i] == e, tag, $sformatf("req[%0d]", i), longint'(req[i]), longint'(e));
    end
    check(rd_data == {mx[ra][15:0], my[ra][15:0]}, "R1", "rd_data",
          longint'(rd_data), longint'({mx[ra][15:0], my[ra][15:0]}));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    for (int i = 0; i < NT; i++) begin mx[i] = 0; my[i] = 0; mk[i] = 0; end
    @(negedge clk);
    step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    rst_n = 1'b1;
    // R1 R3: reset state, all readbacks zero, no requests
    for (int i = 0; i < NT; i++) step(0, 0, 0, i);
    // R1: field placement readback, R4 fractional pattern
    step(1, 0, {16'd3, 16'd7}, 0);
    for (int c = 0; c < 20; c++) step(0, 0, 0, 0);
    // R3: X zero, Y zero
    step(1, 1, {16'd0, 16'd5}, 1);
    step(1, 2, {16'd5, 16'd0}, 2);
    for (int c = 0; c < 6; c++) step(0, 0, 0, 1);
    // R5: ratio exactly one and saturated extreme
    step(1, 1, {16'd9, 16'd9}, 1);
    step(1, 2, {16'hFFFF, 16'd1}, 2);
    for (int c = 0; c < 6; c++) step(0, 0, 0, 2);
    // R5 -> R4 rewrite mid-run restarts phase (R6), R2 others keep running
    step(1, 2, {16'hFFFE, 16'hFFFF}, 2);
    step(1, 3, {16'd1, 16'd2}, 3);
    for (int c = 0; c < 8; c++) step(0, 0, 0, 3);
    // R7: window of Y cycles contains exactly X pulses
    step(1, 2, {16'd5, 16'd13}, 2);
    for (int c = 0; c < 4; c++) step(0, 0, 0, 2);
    win_cnt = 0;
    for (int c = 0; c < 13; c++) begin
      step(0, 0, 0, 2);
      win_cnt += int'(req[2]);
    end
    check(win_cnt == 5, "R7", "window pulses", win_cnt, 5);
    // R6: back-to-back rewrites of the same timer keep restarting
    step(1, 0, {16'd2, 16'd3}, 0);
    step(1, 0, {16'd2, 16'd3}, 0);
    step(0, 0, 0, 0);
    // random phase
    for (int c = 0; c < 4000; c++) begin
      bit we;
      logic [31:0] wd;
      we = ($urandom % 30) == 0;
      if (($urandom % 8) == 0) wd = $urandom;
      else wd = {16'($urandom % 20), 16'($urandom % 20)};
      step(we, int'($urandom % NT), wd, int'($urandom % NT));
    end
    // R3: reset returns everything to stopped
    rst_n = 1'b0;
    step(0, 0, 0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NT; i++) step(0, 0, 0, i);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule